// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block runs the power-down mode of a small microcontroller. When the core signals a halt, the block stops the system clock and holds the port outputs. It sets the power-down status flag and clears the time-out flag. While the core sleeps, four wake sources are watched from an always-on clock: an external reset request, falling edges on enabled pins of an 8-bit port, new interrupt requests, and watchdog overflow.

When a source fires, the block waits out a start-up delay that depends on the source and on the oscillator configuration. It then re-enables the clock and gives a one-cycle resume pulse. The pulse carries a code that tells the core how to continue: a full reset, a reset of only the program counter and stack pointer, execution from the instruction after the halt, or entry to the interrupt vector. An interrupt whose request flag was already set when the halt was taken cannot wake the device.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: In the cycle after `haltReq` is sampled while running, `clkEnable` is 0, `asleep` and `portHold` are 1, `pdfFlag` is 1 and `toFlag` is 0.
- R2: After `rstN` is released, `clkEnable` is 1, `asleep`, `portHold`, `resumePulse`, `pdfFlag` and `toFlag` are 0. A `clrWdtCmd` pulse while running clears `pdfFlag` on the next cycle.
- R3: `wdtOverflow` sets `toFlag` in any state. While asleep it wakes the device with resume code 1 (PC and SP reset), and `pdfFlag` keeps its value.
- R4: `extResetReq` while asleep gives resume code 0 (full reset). The delay is `RST_TICKS` periods of `slowTick`, followed by the oscillator start-up count.
- R5: A falling edge on `portPins[i]` wakes the device with resume code 2 (continue) only when `portWakeEn[i]` is 1. A falling edge on a disabled pin, or any rising edge, leaves the device asleep.
- R6: A new interrupt request wakes the device. The code is 3 (vector) if a newly raised request has its `intEn` bit set and `stackFull` is 0; otherwise it is 2 (continue).
- R7: An `intReq` bit that was already 1 when the halt was taken does not wake the device while it stays 1. A different, newly raised request still does.
- R8: The start-up count is 1024 cycles when `oscCrystal` is 1. With `oscCrystal` at 0 it is 2 cycles if `fastStart` is 1 and 1024 cycles if not. A watchdog or interrupt applied before clock edge 0 produces the resume pulse after edge N, where N is the start-up count. A port edge takes two more cycles for synchronisation.
- R9: `resumePulse` is high for exactly one cycle. `clkEnable` returns to 1 in that same cycle and stays 1 afterwards.
- R10: When several sources fire in the same cycle, the external reset wins over the watchdog, the watchdog over interrupts, and interrupts over the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| haltReq | input | 1 | Core executes halt (one-cycle pulse) |
| clrWdtCmd | input | 1 | Core executes clear-watchdog (pulse) |
| extResetReq | input | 1 | External reset request |
| wdtOverflow | input | 1 | Watchdog overflow pulse |
| slowTick | input | 1 | One-cycle tick of the slow reset-delay timebase |
| oscCrystal | input | 1 | 1 = crystal oscillator configuration |
| fastStart | input | 1 | RC modes: 1 = 2-cycle start-up, 0 = 1024 |
| portPins | input | 8 | Port pin levels |
| portWakeEn | input | 8 | Per-pin falling-edge wake enable |
| intReq | input | NUM_INT | Interrupt request flags |
| intEn | input | NUM_INT | Interrupt enables |
| stackFull | input | 1 | Core stack has no free level |
| clkEnable | output | 1 | System clock gate enable |
| asleep | output | 1 | Device in sleep or wake delay |
| portHold | output | 1 | Hold port output states |
| resumePulse | output | 1 | One-cycle resume strobe |
| resumeType | output | 2 | 0 full reset, 1 PC/SP reset, 2 continue, 3 vector |
| pdfFlag | output | 1 | Power-down status flag |
| toFlag | output | 1 | Time-out status flag |

## Verification
Each source is tried alone: an enabled port pin, a disabled pin and a rising edge, interrupts under every combination of enable and stack state, watchdog overflow and external reset. These runs separate the four resume codes and show that the ignored stimuli have no effect. Pending-before-sleep interrupts are contrasted with fresh ones, and simultaneous sources show the priority order. Randomised wakes vary the oscillator setting, so the exact latencies tell the 2-cycle count from the 1024-cycle count and the synchronised port path from the direct ones.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    RES_FULL = 2'd0,
    RES_PCSP = 2'd1,
    RES_CONT = 2'd2,
    RES_VECT = 2'd3
  } resume_e;

  typedef struct packed {
    logic enterSleep;
    logic clrPdf;
    logic loadRst;
    logic tickRst;
    logic loadOsc;
    logic tickOsc;
  } strobe_t;

  typedef struct packed {
    logic portFall;
    logic newInt;
    logic vecOk;
    logic rstLast;
    logic oscZero;
  } status_t;
endpackage

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int NUM_INT     = 4,
  parameter int RST_TICKS   = 4,
  parameter int START_LONG  = 1024,
  parameter int START_SHORT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [PORT_W-1:0]  portPins,
  input  logic [PORT_W-1:0]  portWakeEn,
  input  logic [NUM_INT-1:0] intReq,
  input  logic [NUM_INT-1:0] intEn,
  input  logic               stackFull,
  input  logic               slowTick,
  input  logic               oscCrystal,
  input  logic               fastStart,
  input  logic               wdtOverflow,
  output status_t            stat,
  output logic               pdfFlag,
  output logic               toFlag
);
  localparam int CNT_W = $clog2(START_LONG);
  localparam int RST_W = $clog2(RST_TICKS + 1);
  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(START_LONG - 1);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(START_SHORT - 1);

  logic [PORT_W-1:0]  syncA, syncB, prevS;
  logic [NUM_INT-1:0] pendMask, freshInt;
  logic [CNT_W-1:0]   oscCnt;
  logic [RST_W-1:0]   rstCnt;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pinSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= 1'b1;
        syncB[i] <= 1'b1;
        prevS[i] <= 1'b1;
      end else begin
        syncA[i] <= portPins[i];
        syncB[i] <= syncA[i];
        prevS[i] <= syncB[i];
      end
    end
  end

  assign freshInt      = intReq & ~pendMask;
  assign stat.portFall = |(prevS & ~syncB & portWakeEn);
  assign stat.newInt   = |freshInt;
  assign stat.vecOk    = (|(freshInt & intEn)) && !stackFull;
  assign stat.rstLast  = slowTick && (rstCnt == RST_W'(1));
  assign stat.oscZero  = (oscCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
      oscCnt   <= '0;
      rstCnt   <= '0;
      pdfFlag  <= 1'b0;
      toFlag   <= 1'b0;
    end else begin
      if (strb.enterSleep) pendMask <= intReq;
      else                 pendMask <= pendMask & intReq;

      if (strb.loadOsc)
        oscCnt <= (oscCrystal || !fastStart) ? LONG_M1 : SHORT_M1;
      else if (strb.tickOsc)
        oscCnt <= oscCnt - 1'b1;

      if (strb.loadRst)
        rstCnt <= RST_W'(RST_TICKS);
      else if (strb.tickRst && slowTick)
        rstCnt <= rstCnt - 1'b1;

      if (strb.enterSleep)  pdfFlag <= 1'b1;
      else if (strb.clrPdf) pdfFlag <= 1'b0;

      if (wdtOverflow)          toFlag <= 1'b1;
      else if (strb.enterSleep) toFlag <= 1'b0;
    end
  end

  // R1
  pdf_on_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterSleep && !wdtOverflow |=> pdfFlag && !toFlag);
  // R3
  to_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtOverflow |=> toFlag);
  // R8
  osc_no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tickOsc |-> oscCnt != '0);
endmodule

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic       clrWdtCmd,
  input  logic       extResetReq,
  input  logic       wdtOverflow,
  input  status_t    stat,
  output strobe_t    strb,
  output logic       clkEnable,
  output logic       asleep,
  output logic       resumePulse,
  output logic [1:0] resumeType
);
  typedef enum logic [2:0] {ST_RUN, ST_SLEEP, ST_RSTW, ST_OSCW, ST_RESUME} state_e;

  state_e  state, stateNxt;
  resume_e rType, rTypeNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    rTypeNxt = rType;
    case (state)
      ST_RUN: begin
        if (haltReq) begin
          stateNxt        = ST_SLEEP;
          strb.enterSleep = 1'b1;
        end else if (clrWdtCmd) begin
          strb.clrPdf = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (extResetReq) begin
          stateNxt     = ST_RSTW;
          strb.loadRst = 1'b1;
          rTypeNxt     = RES_FULL;
        end else if (wdtOverflow) begin
          stateNxt     = ST_OSCW;
          strb.loadOsc = 1'b1;
          rTypeNxt     = RES_PCSP;
        end else if (stat.newInt) begin
          stateNxt     = ST_OSCW;
          strb.loadOsc = 1'b1;
          rTypeNxt     = stat.vecOk ? RES_VECT : RES_CONT;
        end else if (stat.portFall) begin
          stateNxt     = ST_OSCW;
          strb.loadOsc = 1'b1;
          rTypeNxt     = RES_CONT;
        end
      end
      ST_RSTW: begin
        strb.tickRst = 1'b1;
        if (stat.rstLast) begin
          stateNxt     = ST_OSCW;
          strb.loadOsc = 1'b1;
        end
      end
      ST_OSCW: begin
        if (stat.oscZero) stateNxt = ST_RESUME;
        else              strb.tickOsc = 1'b1;
      end
      ST_RESUME: stateNxt = ST_RUN;
      default:   stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      rType <= RES_FULL;
    end else begin
      state <= stateNxt;
      rType <= rTypeNxt;
    end
  end

  assign clkEnable   = (state == ST_RUN) || (state == ST_RESUME);
  assign asleep      = (state == ST_SLEEP) || (state == ST_RSTW) || (state == ST_OSCW);
  assign resumePulse = (state == ST_RESUME);
  assign resumeType  = rType;

  // R9
  resume_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |=> !resumePulse && clkEnable);
  // R9
  clk_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkEnable) |-> resumePulse);
  // R10
  wdt_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SLEEP && wdtOverflow && !extResetReq |=> state == ST_OSCW && rType == RES_PCSP);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_INT     = 4,
  parameter int RST_TICKS   = 4,
  parameter int START_LONG  = 1024,
  parameter int START_SHORT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               haltReq,
  input  logic               clrWdtCmd,
  input  logic               extResetReq,
  input  logic               wdtOverflow,
  input  logic               slowTick,
  input  logic               oscCrystal,
  input  logic               fastStart,
  input  logic [7:0]         portPins,
  input  logic [7:0]         portWakeEn,
  input  logic [NUM_INT-1:0] intReq,
  input  logic [NUM_INT-1:0] intEn,
  input  logic               stackFull,
  output logic               clkEnable,
  output logic               asleep,
  output logic               portHold,
  output logic               resumePulse,
  output logic [1:0]         resumeType,
  output logic               pdfFlag,
  output logic               toFlag
);
  strobe_t strb;
  status_t stat;

  swc_control u_ctrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .clrWdtCmd(clrWdtCmd),
    .extResetReq(extResetReq), .wdtOverflow(wdtOverflow), .stat(stat),
    .strb(strb), .clkEnable(clkEnable), .asleep(asleep),
    .resumePulse(resumePulse), .resumeType(resumeType)
  );

  swc_datapath #(
    .PORT_W(8), .NUM_INT(NUM_INT), .RST_TICKS(RST_TICKS),
    .START_LONG(START_LONG), .START_SHORT(START_SHORT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .portPins(portPins),
    .portWakeEn(portWakeEn), .intReq(intReq), .intEn(intEn),
    .stackFull(stackFull), .slowTick(slowTick), .oscCrystal(oscCrystal),
    .fastStart(fastStart), .wdtOverflow(wdtOverflow), .stat(stat),
    .pdfFlag(pdfFlag), .toFlag(toFlag)
  );

  assign portHold = asleep;
endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI   = 4;
  localparam int RSTT = 4;
  localparam int TP   = 8;

  logic clk = 0, rstN = 0, haltReq = 0, clrWdtCmd = 0, extResetReq = 0;
  logic wdtOverflow = 0, slowTick = 0, oscCrystal = 0, fastStart = 0, stackFull = 0;
  logic [7:0] portPins = 8'hFF, portWakeEn = 8'h00;
  logic [NI-1:0] intReq = '0, intEn = '0;
  logic clkEnable, asleep, portHold, resumePulse, pdfFlag, toFlag;
  logic [1:0] resumeType;

  int checks = 0, failures = 0, cycles = 0, tickCnt = 0;

  sleep_wake_ctrl #(.NUM_INT(NI), .RST_TICKS(RSTT)) dut_i (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .clrWdtCmd(clrWdtCmd),
    .extResetReq(extResetReq), .wdtOverflow(wdtOverflow), .slowTick(slowTick),
    .oscCrystal(oscCrystal), .fastStart(fastStart), .portPins(portPins),
    .portWakeEn(portWakeEn), .intReq(intReq), .intEn(intEn), .stackFull(stackFull),
    .clkEnable(clkEnable), .asleep(asleep), .portHold(portHold),
    .resumePulse(resumePulse), .resumeType(resumeType), .pdfFlag(pdfFlag), .toFlag(toFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tickCnt  <= (tickCnt == TP-1) ? 0 : tickCnt + 1;
    slowTick <= (tickCnt == TP-1);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic int startLen(logic cr, logic fs);
    return (cr || !fs) ? 1024 : 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic doHalt();
    @(negedge clk) haltReq = 1;
    @(negedge clk) haltReq = 0;
  endtask

  task automatic waitResume(output int cyc, output logic [1:0] ty);
    cyc = 0; ty = 2'bxx;
    for (int k = 0; k < 6000; k++) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      wdtOverflow = 0; extResetReq = 0;
      if (resumePulse) begin
        ty = resumeType;
        check(clkEnable == 1, "R9 clk back with pulse", clkEnable, 1);
        @(negedge clk);
        check(resumePulse == 0 && clkEnable == 1, "R9 single pulse", resumePulse, 0);
        return;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int c; logic [1:0] t; int n;

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    rstN = 1;
    @(negedge clk);
    // R2 reset state
    check(clkEnable == 1 && asleep == 0 && portHold == 0 && resumePulse == 0, "R2 reset outputs", {clkEnable, asleep, portHold, resumePulse}, 4'b1000);
    check(pdfFlag == 0 && toFlag == 0, "R2 reset flags", {pdfFlag, toFlag}, 0);

    // R1 halt, R5 enabled pin, R8 fast start
    oscCrystal = 0; fastStart = 1; portWakeEn = 8'h08;
    doHalt();
    check(clkEnable == 0 && asleep == 1 && portHold == 1, "R1 clock gated", {clkEnable, asleep, portHold}, 3'b011);
    check(pdfFlag == 1 && toFlag == 0, "R1 flags", {pdfFlag, toFlag}, 2'b10);
    portPins[3] = 0;
    waitResume(c, t);
    check(t == 2'd2, "R5 port wake code", t, 2);
    check(c == 2 + 3, "R8 port latency short", c, 5);
    portPins[3] = 1; idle(5);

    // R2 clear watchdog clears PDF
    @(negedge clk) clrWdtCmd = 1;
    @(negedge clk) clrWdtCmd = 0;
    check(pdfFlag == 0, "R2 clrWdt clears pdf", pdfFlag, 0);

    // R5 disabled pin and rising edge ignored; R3 watchdog wake
    oscCrystal = 1;
    doHalt();
    portPins[5] = 0; idle(12);
    check(clkEnable == 0 && asleep == 1, "R5 disabled pin ignored", clkEnable, 0);
    portPins[5] = 1; idle(12);
    check(clkEnable == 0 && asleep == 1, "R5 rising edge ignored", clkEnable, 0);
    wdtOverflow = 1;
    waitResume(c, t);
    check(t == 2'd1, "R3 wdt code", t, 1);
    check(c == 1025, "R8 crystal latency", c, 1025);
    check(toFlag == 1 && pdfFlag == 1, "R3 flags after wdt", {toFlag, pdfFlag}, 2'b11);

    // R7 pending interrupt ignored, R6 vector
    oscCrystal = 0; fastStart = 0;
    intReq[0] = 1; intEn = 4'b0101; stackFull = 0;
    doHalt();
    check(toFlag == 0, "R1 halt clears to", toFlag, 0);
    idle(15);
    check(clkEnable == 0 && asleep == 1, "R7 pending int no wake", clkEnable, 0);
    intReq[2] = 1;
    waitResume(c, t);
    check(t == 2'd3, "R6 vector code", t, 3);
    check(c == 1025, "R8 rc slow latency", c, 1025);
    intReq = '0; idle(3);

    // R6 stack full and disabled interrupt continue
    fastStart = 1;
    doHalt(); stackFull = 1; intReq[2] = 1;
    waitResume(c, t);
    check(t == 2'd2, "R6 stack full continue", t, 2);
    intReq = '0; stackFull = 0; idle(3);
    doHalt(); intReq[1] = 1;
    waitResume(c, t);
    check(t == 2'd2, "R6 disabled int continue", t, 2);
    check(c == 3, "R8 int latency short", c, 3);
    intReq = '0; idle(3);

    // R4 external reset
    doHalt(); extResetReq = 1;
    waitResume(c, t);
    check(t == 2'd0, "R4 ext reset code", t, 0);
    check(c >= (RSTT-1)*TP + 3 && c <= RSTT*TP + 4, "R4 ext reset latency", c, RSTT*TP);

    // R10 priorities
    portWakeEn = 8'hFF;
    doHalt(); wdtOverflow = 1; intReq[0] = 1; portPins[0] = 0;
    waitResume(c, t);
    check(t == 2'd1, "R10 wdt over int and port", t, 1);
    intReq = '0; portPins = 8'hFF; idle(5);
    doHalt(); wdtOverflow = 1; extResetReq = 1;
    waitResume(c, t);
    check(t == 2'd0, "R10 ext over wdt", t, 0);
    doHalt(); intReq[3] = 1; intEn[3] = 1; portPins[1] = 0;
    waitResume(c, t);
    check(t == 2'd3, "R10 int over port", t, 3);
    intReq = '0; portPins = 8'hFF; idle(5);

    // random wakes (R5 R6 R3 R8)
    for (int it = 0; it < 25; it++) begin
      int src, p; logic en, sf; logic [1:0] et; int el;
      src = $urandom % 3;
      oscCrystal = $urandom % 2; fastStart = $urandom % 2;
      n = startLen(oscCrystal, fastStart);
      doHalt();
      if (src == 0) begin
        p = $urandom % 8;
        portWakeEn = 8'($urandom) | (8'd1 << p);
        portPins[p] = 0; et = 2'd2; el = n + 3;
      end else if (src == 1) begin
        p = $urandom % NI; en = $urandom % 2; sf = $urandom % 2;
        intEn = '0; intEn[p] = en; stackFull = sf;
        intReq[p] = 1; et = (en && !sf) ? 2'd3 : 2'd2; el = n + 1;
      end else begin
        wdtOverflow = 1; et = 2'd1; el = n + 1;
      end
      waitResume(c, t);
      check(t == et, "R5 R6 R3 random code", t, et);
      check(c == el, "R8 random latency", c, el);
      portPins = 8'hFF; intReq = '0; stackFull = 0; idle(5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule